// File: doc/BRIEF.md
# Flow-Through Burst SRAM Core

This block is a synthesizable synchronous static RAM with a flow-through read path, four-beat linear bursts and byte-lane write masking. On every rising clock edge it decodes one command from its control inputs: deselect, read, write or burst continue. It can also stall, or hold off all commands while a low-power request is asserted. A read returns the word at the registered address combinationally in the same cycle. Writes take the word on the data input at the edge that carries the command.

The bidirectional data bus is split into a data input, a data output and an output-drive flag. The output enable is active low and acts without a clock. The output is also gated off during write cycles and while the block is deselected or asleep. The default size is 256 words of 40 bits arranged as five 8-bit lanes, with two chip selects.

Top module: `fts_ram`

## Requirements
- R1: While and after reset (rst_n low), the block is deselected and dout_en is 0 even with oe_n low.
- R2: With cen_n low, adv_ld low and every cs_n bit low, an edge captures addr and starts a write if we_n is 0, or a read if we_n is 1.
- R3: With cen_n low and adv_ld low, a cs_n vector with any bit high deselects the block. Later continue cycles (adv_ld high) leave it deselected.
- R4: With cen_n low and adv_ld high after a read or write, the address increments in its two low bits modulo 4, and the upper bits stay fixed. The operation is kept, and cs_n and we_n are ignored.
- R5: With cen_n high, an edge changes neither address, operation nor memory, and the outputs keep their state.
- R6: During a read, dout equals the stored word at the registered address in the cycle after the edge. dout_en is 1 when oe_n is 0, and dout is 0 whenever dout_en is 0.
- R7: oe_n acts combinationally. With oe_n high, a read is a dummy read: the address still advances, but dout_en stays 0 until oe_n falls, with no edge needed.
- R8: In a write, lane_we_n bit i low stores din[8i+7:8i] and bit i high keeps that byte. If all five bits are high, it is a dummy write that changes no byte.
- R9: While a write is the current operation, dout_en is 0 whatever oe_n is.
- R10: While sleep or shutdown is 1, dout_en is 0 at once and every command is ignored, including writes. After release the block is deselected, and the memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low; high stalls the edge |
| cs_n | input | 2 | Chip selects, all must be low to select |
| adv_ld | input | 1 | 1 continues the burst, 0 loads a new command |
| we_n | input | 1 | Write enable, active low, sampled on load |
| lane_we_n | input | 5 | Per-byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold request |
| shutdown | input | 1 | Shutdown request, same effect as sleep |
| addr | input | 8 | External word address |
| din | input | 40 | Write data |
| dout | output | 40 | Read data, zero when not driving |
| dout_en | output | 1 | Output drive enable |

## Verification
On every cycle, the assertions check the following:
- the output gating for writes, sleep and a high oe_n;
- that a stalled edge holds address and operation;
- the modulo-4 address step with fixed upper bits on a continue;
- that chip-select misses and continues after a deselect leave the block idle.

Only the bench scenarios can show what the memory actually holds. These cover the full fill and read-back with every burst start offset, and every lane mask including the dummy write. They also show that stalled and sleeping writes leave no trace, and that the oe_n path responds without a clock edge.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        CMD_SLEEP = 3'd0,
        CMD_STALL = 3'd1,
        CMD_DESEL = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4,
        CMD_CONT  = 3'd5
    } cmd_e;
endpackage

// File: rtl/fts_cmd_decode.sv
`timescale 1ns/1ps
module fts_cmd_decode #(
    parameter int NCS = 2
) (
    input  logic           sleep,
    input  logic           shutdown,
    input  logic           cen_n,
    input  logic           adv_ld,
    input  logic [NCS-1:0] cs_n,
    input  logic           we_n,
    output fts_pkg::cmd_e  cmd
);
    import fts_pkg::*;

    // Priority: low-power hold, then stall, then continue, then load.
    always_comb begin
        if (sleep || shutdown)  cmd = CMD_SLEEP;
        else if (cen_n)         cmd = CMD_STALL;
        else if (adv_ld)        cmd = CMD_CONT;
        else if (|cs_n)         cmd = CMD_DESEL;
        else if (!we_n)         cmd = CMD_WRITE;
        else                    cmd = CMD_READ;
    end
endmodule

// File: rtl/fts_burst_step.sv
`timescale 1ns/1ps
module fts_burst_step #(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);
    generate
        if (BURST_W == 0) begin : g_nowrap
            assign nxt = cur;
        end else if (BURST_W >= ADDR_W) begin : g_full
            assign nxt = cur + ADDR_W'(1);
        end else begin : g_wrap
            logic [BURST_W-1:0] low_inc;
            assign low_inc = cur[BURST_W-1:0] + BURST_W'(1);
            assign nxt     = {cur[ADDR_W-1:BURST_W], low_inc};
        end
    endgenerate
endmodule

// File: rtl/fts_lane_mem.sv
`timescale 1ns/1ps
module fts_lane_mem #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 5,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         wr_lane,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lane[i]) begin
                    store[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/fts_ram.sv
`timescale 1ns/1ps
module fts_ram #(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 5,
    parameter int LANE_W  = 8,
    parameter int NCS     = 2,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic [NCS-1:0]          cs_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    shutdown,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    import fts_pkg::*;

    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t            st_d, st_q;
    cmd_e              cmd;
    logic [ADDR_W-1:0] step_addr;
    logic              wr_en_d;
    logic [WORD_W-1:0] rd_word;
    logic              hold_off;

    fts_cmd_decode #(.NCS(NCS)) u_dec (
        .sleep    (sleep),
        .shutdown (shutdown),
        .cen_n    (cen_n),
        .adv_ld   (adv_ld),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .cmd      (cmd)
    );

    fts_burst_step #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_step (
        .cur (st_q.addr),
        .nxt (step_addr)
    );

    always_comb begin
        st_d    = st_q;
        wr_en_d = 1'b0;
        case (cmd)
            CMD_SLEEP: st_d.op = OP_IDLE;
            CMD_STALL: st_d = st_q;
            CMD_DESEL: st_d.op = OP_IDLE;
            CMD_READ: begin
                st_d.op   = OP_READ;
                st_d.addr = addr;
            end
            CMD_WRITE: begin
                st_d.op   = OP_WRITE;
                st_d.addr = addr;
                wr_en_d   = 1'b1;
            end
            CMD_CONT: begin
                if (st_q.op != OP_IDLE) begin
                    st_d.addr = step_addr;
                    wr_en_d   = (st_q.op == OP_WRITE);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.op   <= OP_IDLE;
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fts_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en_d),
        .wr_addr (st_d.addr),
        .wr_lane (~lane_we_n),
        .wr_data (din),
        .rd_addr (st_q.addr),
        .rd_data (rd_word)
    );

    assign hold_off = sleep | shutdown;
    assign dout_en  = (st_q.op == OP_READ) && !oe_n && !hold_off;
    assign dout     = dout_en ? rd_word : '0;
endmodule

// File: rtl/fts_ram_chk.sv
`timescale 1ns/1ps
module fts_ram_chk #(
    parameter int ADDR_W  = 8,
    parameter int NCS     = 2,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic [NCS-1:0]    cs_n,
    input logic              adv_ld,
    input logic              oe_n,
    input logic              sleep,
    input logic              shutdown,
    input fts_pkg::op_e      op_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              dout_en
);
    import fts_pkg::*;

    // R9
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE) |-> !dout_en);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep || shutdown) |-> !dout_en);

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_n && !sleep && !shutdown) |=> ($stable(addr_q) && $stable(op_q)));

    // R3
    desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && (|cs_n) && !sleep && !shutdown) |=> (op_q == OP_IDLE));

    // R3
    desel_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && op_q == OP_IDLE && !sleep && !shutdown) |=> (op_q == OP_IDLE));

    // R4
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && op_q != OP_IDLE && !sleep && !shutdown) |=>
        (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W]) &&
         addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + 1'b1) &&
         op_q == $past(op_q)));

    // R10
    sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep || shutdown) |=> (op_q == OP_IDLE));
endmodule

bind fts_ram fts_ram_chk #(.ADDR_W(ADDR_W), .NCS(NCS), .BURST_W(BURST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .cs_n     (cs_n),
    .adv_ld   (adv_ld),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .shutdown (shutdown),
    .op_q     (st_q.op),
    .addr_q   (st_q.addr),
    .dout_en  (dout_en)
);

// File: tb/fts_ram_test.sv
`timescale 1ns/1ps
module fts_ram_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cen_n;
    logic [1:0]  cs_n;
    logic        adv_ld;
    logic        we_n;
    logic [4:0]  lane_we_n;
    logic        oe_n;
    logic        sleep;
    logic        shutdown;
    logic [7:0]  addr;
    logic [39:0] din;
    logic [39:0] dout;
    logic        dout_en;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fts_ram uut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .cs_n(cs_n), .adv_ld(adv_ld),
        .we_n(we_n), .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep),
        .shutdown(shutdown), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [39:0] pat(logic [7:0] a);
        return {a, a ^ 8'hA5, ~a, a + 8'd17, {a[3:0], a[7:4]}};
    endfunction

    task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic load(logic [7:0] a, logic wr, logic [39:0] d, logic [4:0] lm);
        cen_n = 1'b0; adv_ld = 1'b0; cs_n = 2'b00; we_n = ~wr;
        addr = a; din = d; lane_we_n = lm;
    endtask

    task automatic cont(logic [39:0] d);
        cen_n = 1'b0; adv_ld = 1'b1; cs_n = 2'b11; we_n = 1'b0; din = d;
    endtask

    task automatic read_word(logic [7:0] a, logic [39:0] exp, string tag);
        load(a, 1'b0, '0, 5'h1F);
        tick();
        chk(tag, {39'd0, dout_en}, 40'd1);
        chk(tag, dout, exp);
    endtask

    initial begin
        rst_n = 1'b0; cen_n = 1'b0; cs_n = 2'b11; adv_ld = 1'b1; we_n = 1'b1;
        lane_we_n = 5'h1F; oe_n = 1'b0; sleep = 1'b0; shutdown = 1'b0;
        addr = '0; din = '0;
        tick(); tick();
        chk("R1 during reset", {39'd0, dout_en}, 40'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 after reset", {39'd0, dout_en}, 40'd0);

        // Fill: load write then three continues with we_n/cs_n ignored
        for (int b = 0; b < 256; b += 4) begin
            load(8'(b), 1'b1, pat(8'(b)), 5'h00);
            tick();
            chk("R9 write load", {39'd0, dout_en}, 40'd0);
            for (int k = 1; k < 4; k++) begin
                cont(pat(8'(b + k)));
                we_n = 1'b1;
                lane_we_n = 5'h00;
                tick();
                chk("R9 write cont", {39'd0, dout_en}, 40'd0);
            end
        end

        // Read back with every start offset; wrap within four
        for (int s = 0; s < 256; s++) begin
            read_word(8'(s), pat(8'(s)), "R2/R6 load read");
            for (int k = 1; k < 4; k++) begin
                logic [7:0] ea;
                ea = {8'(s) & 8'hFC} | 8'((s + k) & 3);
                cont('0);
                tick();
                chk("R4 burst read en", {39'd0, dout_en}, 40'd1);
                chk("R4 burst read data", dout, pat(ea));
            end
        end

        // Lane masks at 0x80..0x9F, including dummy write (mask 1F)
        for (int m = 0; m < 32; m++) begin
            logic [7:0]  a;
            logic [39:0] exp;
            a = 8'h80 + 8'(m);
            load(a, 1'b1, ~pat(a), 5'(m));
            tick();
            exp = pat(a);
            for (int i = 0; i < 5; i++)
                if (!m[i]) exp[i*8 +: 8] = ~exp[i*8 +: 8];
            read_word(a, exp, "R8 lane write");
        end

        // Stall: held read, stalled write attempt
        read_word(8'd5, pat(8'd5), "R5 pre");
        load(8'd9, 1'b1, '0, 5'h00);
        cen_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5 stall en", {39'd0, dout_en}, 40'd1);
            chk("R5 stall data", dout, pat(8'd5));
        end
        read_word(8'd9, pat(8'd9), "R5 stalled write ignored");

        // Deselect and continues afterwards
        load(8'd12, 1'b0, '0, 5'h1F);
        cs_n = 2'b01;
        tick();
        chk("R3 deselect", {39'd0, dout_en}, 40'd0);
        chk("R6 zero when off", dout, 40'd0);
        cont('0); cs_n = 2'b00; we_n = 1'b1;
        tick();
        chk("R3 cont after deselect", {39'd0, dout_en}, 40'd0);
        tick();
        chk("R3 cont after deselect 2", {39'd0, dout_en}, 40'd0);

        // cs_n and we_n ignored on continue
        read_word(8'd12, pat(8'd12), "R4 pre");
        cont('0);
        tick();
        chk("R4 cs/we ignored", dout, pat(8'd13));

        // Dummy read and async oe
        oe_n = 1'b1;
        cont('0);
        tick();
        chk("R7 dummy read off", {39'd0, dout_en}, 40'd0);
        oe_n = 1'b0;
        #1;
        chk("R7 async oe en", {39'd0, dout_en}, 40'd1);
        chk("R7 advanced addr", dout, pat(8'd14));

        // Write cycle with oe low keeps outputs off
        load(8'd40, 1'b1, pat(8'd40), 5'h00);
        tick();
        chk("R9 write oe low", {39'd0, dout_en}, 40'd0);

        // Sleep then shutdown
        for (int p = 0; p < 2; p++) begin
            logic [7:0] a;
            a = (p == 0) ? 8'd20 : 8'd24;
            read_word(a, pat(a), "R10 pre");
            if (p == 0) sleep = 1'b1; else shutdown = 1'b1;
            #1;
            chk("R10 off at once", {39'd0, dout_en}, 40'd0);
            load(a, 1'b1, '0, 5'h00);
            tick(); tick();
            chk("R10 held off", {39'd0, dout_en}, 40'd0);
            sleep = 1'b0; shutdown = 1'b0;
            cont('0); cs_n = 2'b00; we_n = 1'b1;
            #1;
            chk("R10 deselected after", {39'd0, dout_en}, 40'd0);
            tick();
            chk("R10 cont stays idle", {39'd0, dout_en}, 40'd0);
            read_word(a, pat(a), "R10 memory kept");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule